// File: doc/BRIEF.md
# Palette Entry Write Sequencer with Pixel Lookup

This block holds a colour palette of 256 entries and lets a host fill it through two byte-wide registers. The host selects an entry by writing its number to an index register. It then sends the red, green and blue components one after another to a single data register. A small sequencer collects the three components and writes them into the palette as one 12-bit entry. It then moves on to the following entry, so a whole palette can be loaded with one index write followed by a continuous stream of data writes.

On the display side, a read port takes an 8-bit pixel value and returns the palette entry one clock later as {R,G,B}, together with a valid flag. Later display logic can use the result directly. Reads and host writes run fully in parallel.

The sequencer has three named states:
- `SEQ_RED`: waiting for the red byte. The red byte is latched and the sequencer moves to `SEQ_GREEN`.
- `SEQ_GREEN`: the green byte is latched and the sequencer moves to `SEQ_BLUE`.
- `SEQ_BLUE`: the blue byte commits the entry, advances the index and returns the sequencer to `SEQ_RED`.

An index write moves the sequencer from any state to `SEQ_RED`. With no host write, the sequencer stays in its current state.

Top module: `clut_write_port`

## Requirements
- R1: After reset the sequencer is in `SEQ_RED`, the entry index is 0 and `pix_valid` is low. Three data writes issued with no prior index write therefore fill entry 0.
- R2: A host write with `host_sel`=0 (index register) loads `host_wdata[7:0]` as the entry index. It also returns the sequencer to `SEQ_RED`, which discards any red or green already collected.
- R3: A host write with `host_sel`=1 (data register) takes its component from `host_wdata[7:4]`, and bits 3:0 are ignored. The first, second and third data writes are red, green and blue. The stored entry is red in bits 11:8, green in bits 7:4 and blue in bits 3:0.
- R4: The palette entry changes only on the blue write. After only red and green have been written, a read of the entry still returns its earlier value.
- R5: After each commit the index goes up by one and wraps from 255 to 0. A continuous stream of data writes therefore fills consecutive entries.
- R6: A read request with `pix_rd`=1 and index `pix_idx` in one cycle gives the entry on `pix_rgb`, with `pix_valid` high, in the following cycle. A cycle with no request gives `pix_valid` low in the following cycle.
- R7: While no read is requested, `pix_rgb` holds its last value.
- R8: If a read and a commit address the same entry in the same cycle, the read returns the value from before the commit. A read in the next cycle returns the new value.
- R9: A cycle with `host_wr`=0 changes neither the index nor the sequencer state, whatever `host_sel` and `host_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one write per cycle |
| host_sel | input | 1 | Register select: 0 index register, 1 data register |
| host_wdata | input | 8 | Host write byte |
| pix_rd | input | 1 | Pixel lookup request |
| pix_idx | input | 8 | Pixel value to look up |
| pix_rgb | output | 12 | Looked-up colour {R,G,B}, one cycle after the request |
| pix_valid | output | 1 | High in the cycle that `pix_rgb` answers a request |

## Verification
The bench loads the whole palette in one stream and reads every entry back. A design that did not advance or wrap the index would leave entries stale and fail these reads. A stream started at entry 254 must wrap into entry 0, which catches a missing wrap or an index that saturates.

Three further cases target the sequencer. A partial triple is followed by a fresh index write; a sequencer that did not return to red would commit a component shifted by one slot. Junk bytes sent with the strobe low would corrupt the entry if idle cycles were taken as writes. A read between green and blue catches a design that writes components piecemeal.

A read that collides with a blue commit must return the old colour and then the new one. A write-first memory would return the new colour one read too early.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        SEQ_RED   = 2'd0,
        SEQ_GREEN = 2'd1,
        SEQ_BLUE  = 2'd2
    } seq_state_e;

    localparam logic SEL_INDEX = 1'b0;
    localparam logic SEL_DATA  = 1'b1;

endpackage

// File: rtl/clut_wr_seq.sv
module clut_wr_seq
    import clut_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COMP_W = 4,
    parameter int IDX_W  = 8,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              commit_en,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [RGB_W-1:0]  commit_rgb
);

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [COMP_W-1:0] red_q, red_d;
    logic [COMP_W-1:0] grn_q, grn_d;
    logic [COMP_W-1:0] comp;
    logic              data_wr;
    logic              index_wr;

    assign comp     = host_wdata[DATA_W-1 -: COMP_W];
    assign data_wr  = host_wr && (host_sel == SEL_DATA);
    assign index_wr = host_wr && (host_sel == SEL_INDEX);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_RED;
            idx_q   <= '0;
            red_q   <= '0;
            grn_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            red_q   <= red_d;
            grn_q   <= grn_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        red_d   = red_q;
        grn_d   = grn_q;
        if (index_wr) begin
            state_d = SEQ_RED;
            idx_d   = host_wdata[IDX_W-1:0];
        end else if (data_wr) begin
            unique case (state_q)
                SEQ_RED: begin
                    red_d   = comp;
                    state_d = SEQ_GREEN;
                end
                SEQ_GREEN: begin
                    grn_d   = comp;
                    state_d = SEQ_BLUE;
                end
                SEQ_BLUE: begin
                    idx_d   = idx_q + 1'b1;
                    state_d = SEQ_RED;
                end
                default: state_d = SEQ_RED;
            endcase
        end
    end

    // Outputs
    always_comb begin
        commit_en  = 1'b0;
        commit_idx = idx_q;
        commit_rgb = {red_q, grn_q, comp};
        unique case (state_q)
            SEQ_BLUE: commit_en = data_wr;
            default:  commit_en = 1'b0;
        endcase
    end

    // R2
    addr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        index_wr |=> (state_q == SEQ_RED) && (idx_q == $past(host_wdata[IDX_W-1:0])));

    // R3
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state_q == SEQ_RED) |=> (state_q == SEQ_GREEN));

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> ($stable(idx_q) && $stable(state_q)));

endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
    parameter int IDX_W = 8,
    parameter int RGB_W = 12,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RGB_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RGB_W-1:0] rd_data,
    output logic             rd_valid
);

    logic [RGB_W-1:0] mem [DEPTH];
    logic [RGB_W-1:0] rd_q;
    logic             vld_q;

    // Array write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read port: old data is returned on a same-entry collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= rd_en;
            if (rd_en) begin
                rd_q <= mem[rd_idx];
            end
        end
    end

    assign rd_data  = rd_q;
    assign rd_valid = vld_q;

    // R6
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R6
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/clut_write_port.sv
module clut_write_port #(
    parameter int DATA_W = 8,
    parameter int COMP_W = 4,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              pix_rd,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb,
    output logic              pix_valid
);

    logic             commit_en;
    logic [IDX_W-1:0] commit_idx;
    logic [RGB_W-1:0] commit_rgb;

    clut_wr_seq #(
        .DATA_W (DATA_W),
        .COMP_W (COMP_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .commit_en  (commit_en),
        .commit_idx (commit_idx),
        .commit_rgb (commit_rgb)
    );

    clut_ram #(
        .IDX_W (IDX_W),
        .RGB_W (RGB_W)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit_en),
        .wr_idx   (commit_idx),
        .wr_data  (commit_rgb),
        .rd_en    (pix_rd),
        .rd_idx   (pix_idx),
        .rd_data  (pix_rgb),
        .rd_valid (pix_valid)
    );

    // R8
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && pix_rd && commit_idx == pix_idx) |=> pix_valid);

endmodule

// File: tb/clut_write_port_test.sv
module clut_write_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        pix_rd = 1'b0;
    logic [7:0]  pix_idx = '0;
    logic [11:0] pix_rgb;
    logic        pix_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [11:0] model [256];
    logic [7:0]  m_idx = 0;
    int          m_st = 0;
    logic [3:0]  m_r = 0, m_g = 0;

    logic [11:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    clut_write_port uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .pix_rd     (pix_rd),
        .pix_idx    (pix_idx),
        .pix_rgb    (pix_rgb),
        .pix_valid  (pix_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, pushes expectations, updates model
    task automatic tick(input bit wr, input bit sel, input logic [7:0] d,
                        input bit rd, input logic [7:0] idx, input string tag);
        host_wr = wr; host_sel = sel; host_wdata = d;
        pix_rd = rd; pix_idx = idx;
        if (rd) begin
            exp_q.push_back(model[idx]);
            tag_q.push_back(tag);
        end
        if (wr) begin
            if (!sel) begin
                m_idx = d; m_st = 0;
            end else begin
                case (m_st)
                    0: begin m_r = d[7:4]; m_st = 1; end
                    1: begin m_g = d[7:4]; m_st = 2; end
                    default: begin
                        model[m_idx] = {m_r, m_g, d[7:4]};
                        m_idx = m_idx + 8'd1;
                        m_st = 0;
                    end
                endcase
            end
        end
        @(negedge clk);
        host_wr = 0; pix_rd = 0;
    endtask

    task automatic wr_idx(input logic [7:0] v);
        tick(1, 0, v, 0, 0, "");
    endtask

    task automatic wr_dat(input logic [7:0] v);
        tick(1, 1, v, 0, 0, "");
    endtask

    task automatic rd(input logic [7:0] idx, input string tag);
        tick(0, 0, 8'h00, 1, idx, tag);
    endtask

    // Monitor: pops and compares each returned colour
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected valid", pix_rgb, 12'h000);
            end else begin
                logic [11:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(pix_rgb === e, t, pix_rgb, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 12'h000, 12'h000);
        finish_run();
    end

    initial begin
        logic [11:0] held;
        for (int i = 0; i < 256; i++) model[i] = 12'h000;
        repeat (3) @(negedge clk);
        // R1 reset values
        check(pix_valid === 1'b0, "R1 valid low in reset", {11'd0, pix_valid}, 12'h000);
        rst_n = 1;
        @(negedge clk);
        check(pix_valid === 1'b0, "R1 valid low after reset", {11'd0, pix_valid}, 12'h000);

        // R1: data without index write fills entry 0, R5 then entry 1
        wr_dat(8'hA3); wr_dat(8'h5C); wr_dat(8'h7F);
        wr_dat(8'h1F); wr_dat(8'h2E); wr_dat(8'h3D);
        rd(0, "R1 entry0 from reset index");
        rd(1, "R5 auto increment to entry1");
        @(negedge clk);
        check(exp_q.size() == 0, "R6 latency drained", 12'h000, 12'h000);

        // R3, R5 fill full palette, low nibbles junk
        wr_idx(8'h00);
        for (int i = 0; i < 256; i++) begin
            wr_dat({i[7:4], 4'hF});
            wr_dat({i[3:0], i[7:4]});
            wr_dat({~i[3:0], 4'h9});
        end
        for (int i = 0; i < 256; i++) rd(i[7:0], "R3 R5 full palette");

        // R6 back-to-back reads and R7 hold
        rd(8'h33, "R6 back to back a");
        rd(8'hC4, "R6 back to back b");
        held = pix_rgb;
        check(pix_valid === 1'b1, "R6 valid after request", {11'd0, pix_valid}, 12'h001);
        tick(0, 0, 8'h00, 0, 8'h77, "");
        check(pix_valid === 1'b0, "R6 valid low when idle", {11'd0, pix_valid}, 12'h000);
        check(pix_rgb === held, "R7 output held", pix_rgb, held);
        tick(0, 1, 8'hFF, 0, 8'h12, "");
        check(pix_rgb === held, "R7 output held 2", pix_rgb, held);

        // R5 wrap 255 -> 0
        wr_idx(8'hFE);
        wr_dat(8'h10); wr_dat(8'h20); wr_dat(8'h30);
        wr_dat(8'h40); wr_dat(8'h50); wr_dat(8'h60);
        wr_dat(8'h70); wr_dat(8'h80); wr_dat(8'h90);
        rd(8'hFE, "R5 entry 254");
        rd(8'hFF, "R5 entry 255");
        rd(8'h00, "R5 wrap to entry 0");

        // R2, R4 partial triple discarded by index write
        wr_idx(8'h1E);
        wr_dat(8'hB0); wr_dat(8'hC0);
        rd(8'h1E, "R4 unchanged before blue");
        wr_idx(8'h1E);
        wr_dat(8'hD0); wr_dat(8'hE0); wr_dat(8'hF0);
        rd(8'h1E, "R2 restart at red");
        check(model[8'h1E] == 12'hDEF, "R2 model sanity", model[8'h1E], 12'hDEF);

        // R9 idle cycles with junk ignored
        wr_idx(8'h14);
        wr_dat(8'h30);
        tick(0, 1, 8'hA0, 0, 0, "");
        tick(0, 0, 8'h77, 0, 0, "");
        wr_dat(8'h60); wr_dat(8'h90);
        rd(8'h14, "R9 idle writes ignored");
        rd(8'h77, "R9 idle index write ignored");

        // R8 same-entry collision returns old, then new
        wr_idx(8'h0A);
        wr_dat(8'h50); wr_dat(8'hA0);
        tick(1, 1, 8'h50, 1, 8'h0A, "R8 collision old value");
        rd(8'h0A, "R8 new value next read");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 all reads answered", 12'h000, 12'h000);
        finish_run();
    end

endmodule